// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire bus that a target device has left holding a line low, for example after the bus controller was reset in the middle of a byte. When a start strobe is accepted, it holds the attached bus controller in reset and lets both open-drain lines float high. After one half period it reads them back through a synchronizer. If either line is still low, it pulses the clock line low and then releases it high, one half period at each level. Before every further pulse it tests the bus again.

The sequence ends in one of two ways. If both lines read high, it ends as recovered. If the pulse limit is reached and the bus is still held, it ends as failed. In both cases the controller reset is removed and a one-cycle reinitialise strobe is issued together with a done strobe. The number of clock pulses issued is reported, so software or a supervisor can tell how deeply the bus was stuck.

Line outputs are open-drain enables: a 1 on an enable pulls the line low, and a 0 releases it.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, both line enables are 0, the controller reset is 0, the pulse count is 0, and the recovered, failed, done, reinit and busy outputs are 0.
- R2: From the cycle after an accepted start until the end cycle, the controller reset output is 1; in the end cycle it is 0.
- R3: The block never drives the data line (sda_oe_o stays 0). The first phase keeps both enables at 0 for HALF_CYC cycles.
- R4: The bus counts as free only when both synchronized readbacks (SYNC_STAGES flops each) are 1. A free bus found at a check ends the sequence as recovered.
- R5: Each clock pulse drives scl_oe_o to 1 for exactly HALF_CYC cycles and then to 0 for HALF_CYC cycles. A check precedes every pulse.
- R6: pulse_cnt_o clears on an accepted start and increments by one at the end of each low phase. It never exceeds MAX_PULSES.
- R7: If the check after MAX_PULSES pulses still finds the bus held, the sequence ends as failed. recovered_o and failed_o are never 1 together. Both hold until the next accepted start clears them.
- R8: done_o and reinit_o are 1 for exactly one cycle, the end cycle. With the start sampled at clock edge e0 and K pulses issued, the end cycle follows edge e0 + HALF_CYC + 1 + K*(2*HALF_CYC+1).
- R9: A start strobe while busy_o is 1 has no effect on timing, count or outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a recovery sequence |
| scl_i | input | 1 | Clock line readback (asynchronous) |
| sda_i | input | 1 | Data line readback (asynchronous) |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low (always 0) |
| ctrl_rst_o | output | 1 | Holds the attached controller in reset |
| reinit_o | output | 1 | One-cycle strobe to reinitialise the controller |
| done_o | output | 1 | One-cycle end-of-sequence strobe |
| recovered_o | output | 1 | Last sequence found the bus free |
| failed_o | output | 1 | Last sequence reached the pulse limit |
| busy_o | output | 1 | Sequence in progress |
| pulse_cnt_o | output | $clog2(MAX_PULSES+1) | Clock pulses issued in the current or last sequence |

## Verification
The assertions assume that the line readbacks are slow compared with the clock. A target releases the data line only on a clock-line rising edge, and it does so at least SYNC_STAGES cycles before the next check. They also assume start is a clean synchronous strobe.

The bench models the bus as wired-AND lines. A target model releases the data line only after a chosen number of observed rising edges on the clock line, or can hold the clock line low permanently. HALF_CYC is kept well above the synchronizer depth, so every release settles before the next check.

// File: rtl/i2c_bus_unstick_pkg.sv
package i2c_bus_unstick_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RELEASE = 3'd1,
    ST_CHECK   = 3'd2,
    ST_LOW     = 3'd3,
    ST_HIGH    = 3'd4,
    ST_FINISH  = 3'd5
  } unstick_state_e;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b1;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b1;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
  parameter int HALF_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int TW = $clog2(HALF_CYC + 1);
  localparam logic [TW-1:0] RELOAD = TW'(HALF_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)           cnt_d = RELOAD;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  // R5: the countdown never leaves the reload range
  assert_timer_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD);
endmodule

// File: rtl/unstick_pulse_ctr.sv
module unstick_pulse_ctr #(
  parameter int MAX_PULSES = 100,
  parameter int CW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          at_max_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == CW'(MAX_PULSES));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_PULSES));
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
  import i2c_bus_unstick_pkg::*;
#(
  parameter int HALF_CYC    = 2000,
  parameter int MAX_PULSES  = 100,
  parameter int SYNC_STAGES = 2,
  parameter int CW          = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          ctrl_rst_o,
  output logic          reinit_o,
  output logic          done_o,
  output logic          recovered_o,
  output logic          failed_o,
  output logic          busy_o,
  output logic [CW-1:0] pulse_cnt_o
);
  unstick_state_e state_q, state_d;
  logic scl_s, sda_s, bus_free;
  logic tmr_load, tmr_exp;
  logic cnt_clr, cnt_inc, cnt_max;
  logic rec_q, rec_d, fail_q, fail_d;

  unstick_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
  unstick_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

  unstick_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .expired_o(tmr_exp));

  unstick_pulse_ctr #(.MAX_PULSES(MAX_PULSES), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .cnt_o(pulse_cnt_o), .at_max_o(cnt_max));

  assign bus_free = scl_s & sda_s;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    rec_d    = rec_q;
    fail_d   = fail_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_RELEASE;
        tmr_load = 1'b1;
        cnt_clr  = 1'b1;
        rec_d    = 1'b0;
        fail_d   = 1'b0;
      end
      ST_RELEASE: if (tmr_exp) state_d = ST_CHECK;
      ST_CHECK: begin
        if (bus_free) begin
          state_d = ST_FINISH;
          rec_d   = 1'b1;
        end else if (cnt_max) begin
          state_d = ST_FINISH;
          fail_d  = 1'b1;
        end else begin
          state_d  = ST_LOW;
          tmr_load = 1'b1;
        end
      end
      ST_LOW: if (tmr_exp) begin
        state_d  = ST_HIGH;
        tmr_load = 1'b1;
        cnt_inc  = 1'b1;
      end
      ST_HIGH:   if (tmr_exp) state_d = ST_CHECK;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rec_q   <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rec_q   <= rec_d;
      fail_q  <= fail_d;
    end
  end

  assign scl_oe_o    = (state_q == ST_LOW);
  assign sda_oe_o    = 1'b0;
  assign busy_o      = (state_q != ST_IDLE);
  assign ctrl_rst_o  = busy_o && (state_q != ST_FINISH);
  assign done_o      = (state_q == ST_FINISH);
  assign reinit_o    = (state_q == ST_FINISH);
  assign recovered_o = rec_q;
  assign failed_o    = fail_q;

  assert_outcome_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(recovered_o && failed_o));
  assert_rst_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rst_o) |-> done_o);
  assert_pulse_needs_held_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe_o) |-> !$past(bus_free));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_fail_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failed_o) |-> (pulse_cnt_o == CW'(MAX_PULSES)));
endmodule

// File: tb/i2c_bus_unstick_tb.sv
module i2c_bus_unstick_tb;
  localparam int H   = 4;
  localparam int MAXP = 6;
  localparam int CW  = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scl_oe, sda_oe, ctrl_rst, reinit, done, rec, fail, busy;
  logic [CW-1:0] pcnt;

  int  k_target = 0;
  bit  scl_stuck = 1'b0;
  bit  clr_rises = 1'b0;
  int  rises = 0;
  logic scl_prev = 1'b1;

  int compared = 0;
  int mismatched = 0;

  wire scl_line = !scl_oe && !scl_stuck;
  wire sda_line = !sda_oe && !(rises < k_target);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    scl_prev <= scl_line;
    if (clr_rises)                 rises <= 0;
    else if (scl_line && !scl_prev) rises <= rises + 1;
  end

  i2c_bus_unstick #(.HALF_CYC(H), .MAX_PULSES(MAXP), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .ctrl_rst_o(ctrl_rst), .reinit_o(reinit),
    .done_o(done), .recovered_o(rec), .failed_o(fail), .busy_o(busy), .pulse_cnt_o(pcnt));

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sequence; k = rises before target lets go, stuck = clock line held
  task automatic run(input int k, input bit stuck, input bit poke);
    int n, low_cnt, rst_bad, sda_bad, exp_k, exp_d;
    bit exp_rec;
    k_target  = k;
    scl_stuck = stuck;
    @(negedge clk); clr_rises = 1'b1;
    @(negedge clk); clr_rises = 1'b0;
    repeat (3) @(negedge clk);
    exp_rec = !stuck && (k <= MAXP);
    exp_k   = exp_rec ? k : MAXP;
    exp_d   = H + 1 + exp_k * (2*H + 1);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    n = 0; low_cnt = 0; rst_bad = 0; sda_bad = 0;
    while (!done && n < 400) begin
      if (scl_oe) low_cnt++;
      if (!ctrl_rst) rst_bad++;
      if (sda_oe) sda_bad++;
      if (poke && n == H + 2) start = 1'b1;
      @(posedge clk); n++;
      @(negedge clk); start = 1'b0;
    end
    check($sformatf("R8 end cycle k=%0d stuck=%0d", k, stuck), n, exp_d);
    check("R5 low cycles", low_cnt, exp_k * H);
    check("R2 controller reset held", rst_bad, 0);
    check("R3 data line never driven", sda_bad + int'(sda_oe), 0);
    check("R2 reset released at end", int'(ctrl_rst), 0);
    check("R8 reinit strobe", int'(reinit), 1);
    check("R4 recovered flag", int'(rec), int'(exp_rec));
    check("R7 failed flag", int'(fail), int'(!exp_rec));
    check("R6 pulse count", int'(pcnt), exp_k);
    @(negedge clk);
    check("R8 done one cycle", int'(done) + int'(reinit), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      check("R9 start while busy ignored", int'(busy), 0);
    end
    check("R7 flags held", int'(rec), int'(exp_rec));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset scl_oe", int'(scl_oe), 0);
    check("R1 reset sda_oe", int'(sda_oe), 0);
    check("R1 reset ctrl_rst", int'(ctrl_rst), 0);
    check("R1 reset flags", int'(rec) + int'(fail) + int'(done) + int'(reinit) + int'(busy), 0);
    check("R1 reset count", int'(pcnt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k <= MAXP + 2; k++) run(k, 1'b0, 1'b0);
    run(MAXP, 1'b1, 1'b0);
    run(2, 1'b0, 1'b1);
    run(MAXP + 1, 1'b0, 1'b1);
    run(0, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule